// File: doc/BRIEF.md
# Interrupt Request Gating Unit

This unit sits beside a small processor core. It gathers request flags from six sources: two external pins, three timers, and one serial source that merges an SPI completion flag with UART receive and transmit flags. An 8-bit enable register gates these flags. Once per machine cycle, on the poll strobe, the unit picks the highest-ranked enabled request and presents its source number to the core. It holds that number until the core acknowledges it.

Timer overflow flags reach the poll logic with different delays. The Timer 0 and Timer 1 overflow flags are set late in the machine cycle, so the first poll that sees them is the one in the following cycle. The Timer 2 overflow flag is set early, so the poll in the same cycle sees it. The Timer 2 request is the OR of an overflow flag and an external-event flag. Taking the Timer 2 vector clears neither flag; only explicit software clear strobes clear them.

Top module: `irq_gate`

## Requirements
- R1: After reset the following are all zero: the enable register readback, `irq_req`, `pend` and `tf_flags`.
- R2: A write loads the enable register. The bit layout is: bit 7 global enable, bit 5 Timer 2, bit 4 serial, bit 3 Timer 1, bit 2 external 1, bit 1 Timer 0, bit 0 external 0. Bit 6 ignores writes and reads as 0.
- R3: While the global enable bit is 0, `pend` is zero and no request is presented.
- R4: `pend` has one bit per source index: 0 external 0, 1 Timer 0, 2 external 1, 3 Timer 1, 4 serial, 5 Timer 2. While global enable is 1, bit i is the source's request ANDed with enable bit i.
- R5: On a poll strobe with no outstanding request and a nonzero `pend`, `irq_req` rises on the next clock and `irq_vec` carries the lowest set index of `pend`.
- R6: While `irq_req` is high and not acknowledged, `irq_req` and `irq_vec` hold. No new vector is presented, even if a higher-ranked source becomes pending.
- R7: A Timer 2 overflow pulse raises `pend[5]` before the next poll, and that poll presents it. A Timer 0 or Timer 1 overflow pulse is first seen by the poll strobe after the next one.
- R8: The Timer 2 request is the OR of its overflow flag and its external flag. Acknowledging vector 5 clears neither flag.
- R9: Acknowledging vector 1 clears the Timer 0 overflow flag. Acknowledging vector 3 clears the Timer 1 overflow flag.
- R10: `ext_edge` bit i = 1 selects edge mode for external source i. In edge mode a falling pin edge sets the flag and an acknowledge clears it. In level mode (bit i = 0) the request follows the low pin and an acknowledge has no effect.
- R11: The serial request is the OR of the three bits of `ser_src`, and an acknowledge leaves it unchanged.
- R12: `tf_flags` is {Timer 2 external, Timer 2 overflow, Timer 1 overflow, Timer 0 overflow}. Bit i of `clr_flags` clears bit i of `tf_flags` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register readback |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per-pin edge (1) / level (0) mode |
| tmr_ovf | input | 2 | Timer 1 / Timer 0 overflow pulses |
| t2_ovf | input | 1 | Timer 2 overflow pulse |
| t2_ext | input | 1 | Timer 2 external event pulse |
| ser_src | input | 3 | Serial flags (SPI done, UART receive, UART transmit) |
| clr_flags | input | 4 | Software clear strobes for `tf_flags` |
| poll_tick | input | 1 | Machine-cycle poll strobe |
| pend | output | 6 | Enabled pending requests by source index |
| irq_req | output | 1 | Vector presented to the core |
| irq_vec | output | 3 | Source index of the presented vector |
| irq_ack | input | 1 | Core acknowledge |
| tf_flags | output | 4 | Timer flag readback |

## Verification
A stuck or corrupted enable bit shows up in `pend` on the clock after the write, and in `en_rdata` immediately after that clock. A timer flag staged at the wrong time moves the first presented vector one poll strobe early or late. An acknowledge that clears too much or too little shows in `tf_flags` or `pend` on the next clock. A wrong priority or a broken hold shows on `irq_vec` one clock after a poll strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC      = 6;
    localparam int VW        = $clog2(NSRC);
    localparam int EN_W      = 8;
    localparam int EN_GLOBAL = EN_W - 1;
    localparam int EN_RSVD   = EN_W - 2;
    localparam int NEXT      = 2;
    localparam int NTF       = 4;

    typedef enum logic [VW-1:0] {
        SRC_EX0 = 3'd0,
        SRC_TM0 = 3'd1,
        SRC_EX1 = 3'd2,
        SRC_TM1 = 3'd3,
        SRC_SER = 3'd4,
        SRC_TM2 = 3'd5
    } src_e;

    // lowest set index wins
    function automatic logic [VW-1:0] pick_first(input logic [NSRC-1:0] v);
        logic [VW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = VW'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] en
);
    localparam logic [EN_W-1:0] WMASK = ~(EN_W'(1) << EN_RSVD);

    typedef struct packed {
        logic [EN_W-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.en = wdata & WMASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en = st_q.en;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poll_tick,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] ext_edge,
    input  logic [NEXT-1:0] tmr_ovf,
    input  logic            t2_ovf,
    input  logic            t2_ext,
    input  logic [2:0]      ser_src,
    input  logic [NTF-1:0]  clr_flags,
    input  logic            ack_fire,
    input  logic [VW-1:0]   ack_vec,
    output logic [NSRC-1:0] src_req,
    output logic [NTF-1:0]  tf_flags
);
    typedef struct packed {
        logic [NEXT-1:0] ext_prev;
        logic [NEXT-1:0] ext_flag;
        logic [NEXT-1:0] tf;
        logic [NEXT-1:0] tf_vis;
        logic            tf2;
        logic            exf2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NEXT; i++) begin
            logic fall, ext_ack, tm_clr;
            fall    = st_q.ext_prev[i] & ~ext_n[i];
            ext_ack = ack_fire && (ack_vec == VW'(2 * i));
            tm_clr  = clr_flags[i] || (ack_fire && (ack_vec == VW'(2 * i + 1)));
            if (ext_edge[i]) st_d.ext_flag[i] = (st_q.ext_flag[i] & ~ext_ack) | fall;
            else             st_d.ext_flag[i] = ~ext_n[i];
            // late-set timer flag: staged for the poll of the next machine cycle
            st_d.tf[i] = (st_q.tf[i] & ~tm_clr) | tmr_ovf[i];
            if (tm_clr)         st_d.tf_vis[i] = 1'b0;
            else if (poll_tick) st_d.tf_vis[i] = st_q.tf[i];
        end
        st_d.ext_prev = ext_n;
        st_d.tf2  = (st_q.tf2  & ~clr_flags[2]) | t2_ovf;
        st_d.exf2 = (st_q.exf2 & ~clr_flags[3]) | t2_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ext_prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        src_req          = '0;
        src_req[SRC_EX0] = st_q.ext_flag[0];
        src_req[SRC_TM0] = st_q.tf_vis[0];
        src_req[SRC_EX1] = st_q.ext_flag[1];
        src_req[SRC_TM1] = st_q.tf_vis[1];
        src_req[SRC_SER] = |ser_src;
        src_req[SRC_TM2] = st_q.tf2 | st_q.exf2;
    end

    assign tf_flags = {st_q.exf2, st_q.tf2, st_q.tf};
endmodule

// File: rtl/irq_poll.sv
module irq_poll
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poll_tick,
    input  logic [NSRC-1:0] src_req,
    input  logic [EN_W-1:0] en,
    input  logic            irq_ack,
    output logic [NSRC-1:0] pend,
    output logic            irq_req,
    output logic [VW-1:0]   irq_vec,
    output logic            ack_fire
);
    typedef struct packed {
        logic          req;
        logic [VW-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    assign pend     = en[EN_GLOBAL] ? (src_req & en[NSRC-1:0]) : '0;
    assign ack_fire = irq_ack & st_q.req;

    always_comb begin
        st_d = st_q;
        if (ack_fire) begin
            st_d.req = 1'b0;
        end else if (poll_tick && !st_q.req && (|pend)) begin
            st_d.req = 1'b1;
            st_d.vec = pick_first(pend);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req = st_q.req;
    assign irq_vec = st_q.vec;
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic [EN_W-1:0] en_wdata,
    output logic [EN_W-1:0] en_rdata,
    input  logic [NEXT-1:0] ext_n,
    input  logic [NEXT-1:0] ext_edge,
    input  logic [NEXT-1:0] tmr_ovf,
    input  logic            t2_ovf,
    input  logic            t2_ext,
    input  logic [2:0]      ser_src,
    input  logic [NTF-1:0]  clr_flags,
    input  logic            poll_tick,
    output logic [NSRC-1:0] pend,
    output logic            irq_req,
    output logic [VW-1:0]   irq_vec,
    input  logic            irq_ack,
    output logic [NTF-1:0]  tf_flags
);
    logic [NSRC-1:0] src_req;
    logic            ack_fire;

    irq_en_reg u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .en    (en_rdata)
    );

    irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_tick (poll_tick),
        .ext_n     (ext_n),
        .ext_edge  (ext_edge),
        .tmr_ovf   (tmr_ovf),
        .t2_ovf    (t2_ovf),
        .t2_ext    (t2_ext),
        .ser_src   (ser_src),
        .clr_flags (clr_flags),
        .ack_fire  (ack_fire),
        .ack_vec   (irq_vec),
        .src_req   (src_req),
        .tf_flags  (tf_flags)
    );

    irq_poll u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_tick (poll_tick),
        .src_req   (src_req),
        .en        (en_rdata),
        .irq_ack   (irq_ack),
        .pend      (pend),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .ack_fire  (ack_fire)
    );
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [EN_W-1:0] en_rdata,
    input logic [NEXT-1:0] tmr_ovf,
    input logic [NTF-1:0]  clr_flags,
    input logic            poll_tick,
    input logic [NSRC-1:0] pend,
    input logic            irq_req,
    input logic [VW-1:0]   irq_vec,
    input logic            irq_ack,
    input logic [NTF-1:0]  tf_flags
);
    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_rdata[EN_RSVD] == 1'b0);

    // R3
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rdata[EN_GLOBAL] |-> pend == '0);

    // R5
    launch_on_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(poll_tick) && $past(|pend));

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

    // R8
    t2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && irq_vec == SRC_TM2 && tf_flags[2] && !clr_flags[2]
        |=> tf_flags[2]);

    // R9
    t0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && irq_vec == SRC_TM0 && !tmr_ovf[0] |=> !tf_flags[0]);

    // R9
    t1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && irq_vec == SRC_TM1 && !tmr_ovf[1] |=> !tf_flags[1]);
endmodule

bind irq_gate irq_gate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_rdata  (en_rdata),
    .tmr_ovf   (tmr_ovf),
    .clr_flags (clr_flags),
    .poll_tick (poll_tick),
    .pend      (pend),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_ack   (irq_ack),
    .tf_flags  (tf_flags)
);

// File: tb/irq_gate_test.sv
`timescale 1ns/1ps
module irq_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic [7:0] en_rdata;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] ext_edge = 2'b00;
    logic [1:0] tmr_ovf = '0;
    logic       t2_ovf = 1'b0;
    logic       t2_ext = 1'b0;
    logic [2:0] ser_src = '0;
    logic [3:0] clr_flags = '0;
    logic       poll_tick = 1'b0;
    logic [5:0] pend;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic       irq_ack = 1'b0;
    logic [3:0] tf_flags;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_gate uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic tick();
        poll_tick = 1'b1; cyc(); poll_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        en_wr = 1'b1; en_wdata = v; cyc(); en_wr = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
    endtask

    task automatic clr_all();
        clr_flags = 4'hF; cyc(); clr_flags = '0;
    endtask

    function automatic int lowest(input logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1
        chk("R1 en", en_rdata, 0);
        chk("R1 req", irq_req, 0);
        chk("R1 pend", pend, 0);
        chk("R1 flags", tf_flags, 0);

        // R2 full sweep of write values
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            chk("R2 readback", en_rdata, v & 8'hBF);
        end
        wr(8'h00);

        // R3 global off with every source active
        ext_n = 2'b00; ser_src = 3'b111; tmr_ovf = 2'b11; t2_ovf = 1'b1; cyc();
        tmr_ovf = '0; t2_ovf = 1'b0;
        tick(); tick();
        wr(8'h3F);
        chk("R3 pend", pend, 0);
        tick();
        chk("R3 req", irq_req, 0);
        wr(8'h00); ext_n = 2'b11; ser_src = '0; clr_all(); cyc();

        // R4 R5 R11: sweep enables x source patterns (level mode)
        for (int k = 0; k < 64; k++) begin
            for (int p = 0; p < 64; p++) begin
                logic [5:0] pb, ex;
                pb = 6'(p);
                ex = pb & 6'(k);
                ext_n = {~pb[2], ~pb[0]};
                ser_src = pb[4] ? 3'(1 << (k % 3)) : 3'b000;
                tmr_ovf = {pb[3], pb[1]}; t2_ovf = pb[5];
                cyc();
                tmr_ovf = '0; t2_ovf = 1'b0;
                tick(); tick();
                wr(8'h80 | 8'(k));
                chk("R4 pend", pend, ex);
                tick();
                chk("R5 req", irq_req, (ex != 0) ? 1 : 0);
                if (ex != 0) begin
                    chk("R5 vec", irq_vec, lowest(ex));
                    ack();
                    // R11 serial request unaffected by acknowledge
                    if (pb[4] && k[4]) chk("R11 ser kept", pend[4], 1);
                end
                wr(8'h00); ext_n = 2'b11; ser_src = '0; clr_all(); cyc();
            end
        end

        // R7 R9 Timer 0 latency and clear on acknowledge
        wr(8'hA2);
        tmr_ovf = 2'b01; cyc(); tmr_ovf = '0;
        chk("R7 t0 not yet", pend, 0);
        chk("R12 t0 flag", tf_flags, 4'b0001);
        tick();
        chk("R7 t0 first poll", irq_req, 0);
        tick();
        chk("R7 t0 second poll", irq_req, 1);
        chk("R7 t0 vec", irq_vec, 1);
        ack();
        chk("R9 t0 cleared", tf_flags, 0);
        chk("R9 t0 pend", pend, 0);

        // R7 R8 Timer 2 same-cycle poll, not cleared by ack
        t2_ovf = 1'b1; cyc(); t2_ovf = 1'b0;
        chk("R7 t2 pend", pend, 6'h20);
        tick();
        chk("R7 t2 req", irq_req, 1);
        chk("R7 t2 vec", irq_vec, 5);
        ack();
        chk("R8 tf2 kept", tf_flags, 4'b0100);
        chk("R8 pend kept", pend, 6'h20);
        clr_flags = 4'b0100; cyc(); clr_flags = '0;
        chk("R12 tf2 clr", tf_flags, 0);
        chk("R8 pend gone", pend, 0);
        t2_ext = 1'b1; cyc(); t2_ext = 1'b0;
        chk("R8 exf2 req", pend, 6'h20);
        chk("R12 exf2 flag", tf_flags, 4'b1000);
        clr_flags = 4'b1000; cyc(); clr_flags = '0;
        chk("R12 exf2 clr", tf_flags, 0);

        // R6 hold while outstanding
        wr(8'hBF);
        t2_ovf = 1'b1; cyc(); t2_ovf = 1'b0;
        tick();
        ext_n = 2'b10; cyc();
        tick();
        chk("R6 req held", irq_req, 1);
        chk("R6 vec held", irq_vec, 5);
        ack();
        tick();
        chk("R6 next vec", irq_vec, 0);
        ack();
        chk("R10 level kept", pend[0], 1);
        ext_n = 2'b11; clr_all(); cyc();
        chk("R10 level released", pend, 0);

        // R10 edge mode
        ext_edge = 2'b11;
        ext_n = 2'b01; cyc();
        chk("R10 edge set", pend, 6'h04);
        tick();
        chk("R10 edge vec", irq_vec, 2);
        ack();
        chk("R10 edge cleared", pend, 0);
        ext_n = 2'b11; cyc(); cyc();
        chk("R10 rise no set", pend, 0);

        // R9 Timer 1
        tmr_ovf = 2'b10; cyc(); tmr_ovf = '0;
        tick(); tick();
        chk("R9 t1 vec", irq_vec, 3);
        ack();
        chk("R9 t1 cleared", tf_flags, 0);

        // R12 software clear of Timer 0 flag
        tmr_ovf = 2'b01; cyc(); tmr_ovf = '0;
        clr_flags = 4'b0001; cyc(); clr_flags = '0;
        chk("R12 t0 clr", tf_flags, 0);
        tick(); tick();
        chk("R12 t0 no req", irq_req, 0);

        finish_run();
    end
endmodule